// File: doc/BRIEF.md
# Microcoded Qualifier-Driven Sequencer

This block is the sequencing core of a small algorithmic state machine. An 8-bit state register addresses an external sequence ROM. The ROM returns a control word combinationally. The word names one qualifier out of 36 candidate lines, a branch target, a polarity bit, loop-counter commands and a single flag operation. When the chosen qualifier, after polarity, is true, the state register takes the branch target. Otherwise it advances by one.

Qualifiers are chosen through two mux levels and captured into a one-bit register before they can steer the state. The block runs in two phases. In a cycle with `step_i` low, the selected qualifier is sampled. In a cycle with `step_i` high, the state, the flags and the loop counter move together. A 4-bit loop counter lets a group of states run up to 16 times. Its wrap indication is itself one of the 36 qualifiers. A power-up reset or an interface-clear input returns everything to zero on the next clock edge.

Control word layout: bits [5:0] select the qualifier, [13:6] hold the branch target, [14] inverts the qualifier, [15] clears the loop counter, [16] increments it, [21:17] give the flag index, and [23:22] give the flag operation.

Top module: `asm_sequencer`

## Requirements
- R1: On a clock edge with `rst_n` low or `ifc_i` high, the state, all 17 flags, the loop count, the wrap indication and the sampled qualifier become 0.
- R2: On an edge with `step_i` low, the state, the flags, the loop count and the wrap indication keep their values.
- R3: On an edge with `step_i` high and the sampled qualifier equal to 1, the state loads the branch target in bits [13:6].
- R4: On an edge with `step_i` high and the sampled qualifier equal to 0, the state increments modulo 256, so 255 is followed by 0.
- R5: Select code c in 0..34 picks `qual_i[c]`. Code 35 picks the loop wrap indication. Codes 36..63 read as 0.
- R6: When bit [14] is 1, the selected qualifier is inverted before it is sampled.
- R7: The qualifier register loads only on edges with `step_i` low. While `step_i` is high, the value sampled earlier steers the state, and changes on `qual_i` have no effect.
- R8: On a step edge, flag operation 01 sets flag[idx] and operation 10 clears it. Operations 00 and 11, and any index of 17 or above, leave all flags unchanged.
- R9: On a step edge, bit [15] clears the loop count and the wrap indication, and takes priority over bit [16]. Bit [16] alone increments the count. The step that wraps the count from 15 to 0 sets the wrap indication, and it stays set until the next clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous power-up reset, active low |
| ifc_i | input | 1 | Synchronous interface clear, active high |
| step_i | input | 1 | High: advance phase. Low: qualifier sampling phase |
| qual_i | input | 35 | External qualifier lines 0..34 |
| ctrl_i | input | 24 | Control word from the sequence ROM |
| state_o | output | 8 | State register, which addresses the ROM |
| flags_o | output | 17 | Internal flag bits |
| loop_cnt_o | output | 4 | Loop counter value |
| loop_tc_o | output | 1 | Sticky loop wrap indication |

## Verification
A wrong qualifier select, polarity or sampling instant shows on `state_o` after the next step edge, as a branch where an increment was expected or the reverse. From then on, the ROM words fetched by the state also diverge. A fault in the flag or loop logic shows on `flags_o` or `loop_cnt_o` one edge after the step. It shows again through `state_o` once code 35 is selected. The bench compares every output after every edge against a model, so a divergence is reported within one cycle of its cause.

// File: rtl/asm_sequencer.sv
module asm_sequencer #(
  parameter int ST_W   = 8,
  parameter int FLAG_N = 17,
  parameter int LOOP_W = 4,
  parameter int NQ_EXT = 35
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ifc_i,
  input  logic                 step_i,
  input  logic [NQ_EXT-1:0]    qual_i,
  input  logic [23:0]          ctrl_i,
  output logic [ST_W-1:0]      state_o,
  output logic [FLAG_N-1:0]    flags_o,
  output logic [LOOP_W-1:0]    loop_cnt_o,
  output logic                 loop_tc_o
);
  localparam int SEL_W  = 6;
  localparam int FIDX_W = $clog2(FLAG_N);
  localparam int NSEL   = 1 << SEL_W;
  localparam int NGRP   = NSEL / 8;
  localparam int J_LO   = SEL_W;
  localparam int INV_B  = J_LO + ST_W;
  localparam int LCLR_B = INV_B + 1;
  localparam int LINC_B = INV_B + 2;
  localparam int FIDX_LO = INV_B + 3;
  localparam int FOP_LO  = FIDX_LO + FIDX_W;

  logic [SEL_W-1:0]  sel;
  logic [ST_W-1:0]   jump;
  logic              inv, lclr, linc;
  logic [FIDX_W-1:0] fidx;
  logic [1:0]        fop;

  assign sel  = ctrl_i[SEL_W-1:0];
  assign jump = ctrl_i[J_LO +: ST_W];
  assign inv  = ctrl_i[INV_B];
  assign lclr = ctrl_i[LCLR_B];
  assign linc = ctrl_i[LINC_B];
  assign fidx = ctrl_i[FIDX_LO +: FIDX_W];
  assign fop  = ctrl_i[FOP_LO +: 2];

  logic             clr;
  logic             qual_q;
  logic [NSEL-1:0]  qpad;
  logic [NGRP-1:0]  lvl1;
  logic             picked;

  assign clr  = !rst_n || ifc_i;
  assign qpad = {{(NSEL-NQ_EXT-1){1'b0}}, loop_tc_o, qual_i};

  for (genvar g = 0; g < NGRP; g++) begin : g_lvl1
    assign lvl1[g] = qpad[g*8 + sel[2:0]];
  end
  assign picked = lvl1[sel[SEL_W-1:3]] ^ inv;

  always_ff @(posedge clk) begin
    if (clr)          qual_q <= 1'b0;
    else if (!step_i) qual_q <= picked;
  end

  always_ff @(posedge clk) begin
    if (clr)         state_o <= '0;
    else if (step_i) state_o <= qual_q ? jump : state_o + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (clr) flags_o <= '0;
    else if (step_i && int'(fidx) < FLAG_N) begin
      if (fop == 2'b01)      flags_o[fidx] <= 1'b1;
      else if (fop == 2'b10) flags_o[fidx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      loop_cnt_o <= '0;
      loop_tc_o  <= 1'b0;
    end else if (step_i) begin
      if (lclr) begin
        loop_cnt_o <= '0;
        loop_tc_o  <= 1'b0;
      end else if (linc) begin
        loop_cnt_o <= loop_cnt_o + 1'b1;
        if (&loop_cnt_o) loop_tc_o <= 1'b1;
      end
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    clr |=> (state_o == '0 && flags_o == '0 && loop_cnt_o == '0 && !loop_tc_o));

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (clr)
    !step_i |=> ($stable(state_o) && $stable(flags_o) && $stable(loop_cnt_o) && $stable(loop_tc_o)));

  assert_jump_loads_R3: assert property (@(posedge clk) disable iff (clr)
    (step_i && qual_q) |=> state_o == $past(jump));

  assert_increment_R4: assert property (@(posedge clk) disable iff (clr)
    (step_i && !qual_q) |=> state_o == $past(state_o) + 1'b1);

  assert_qual_held_R7: assert property (@(posedge clk) disable iff (clr)
    step_i |=> $stable(qual_q));

  assert_flag_single_R8: assert property (@(posedge clk) disable iff (clr)
    step_i |=> $countones(flags_o ^ $past(flags_o)) <= 1);

  assert_tc_sets_R9: assert property (@(posedge clk) disable iff (clr)
    (step_i && !lclr && linc && loop_cnt_o == '1) |=> (loop_tc_o && loop_cnt_o == '0));
endmodule

// File: tb/asm_sequencer_bench.sv
module asm_sequencer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, ifc = 1'b0, step = 1'b0;
  logic [34:0] qual = '0;
  logic [23:0] ctrl = '0;
  logic [7:0]  state;
  logic [16:0] flags;
  logic [3:0]  cnt;
  logic        tc;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [7:0]  m_state = '0;
  logic [16:0] m_flags = '0;
  logic [3:0]  m_cnt = '0;
  logic        m_tc = 1'b0, m_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asm_sequencer u_asm_sequencer (
    .clk(clk), .rst_n(rst_n), .ifc_i(ifc), .step_i(step), .qual_i(qual),
    .ctrl_i(ctrl), .state_o(state), .flags_o(flags), .loop_cnt_o(cnt), .loop_tc_o(tc));

  function automatic logic [23:0] mkw(input int sel, input int jmp, input bit inv,
      input bit lclr, input bit linc, input int fidx, input int fop);
    return {fop[1:0], fidx[4:0], linc, lclr, inv, jmp[7:0], sel[5:0]};
  endfunction

  function automatic logic [23:0] rom(input logic [7:0] s);
    logic [23:0] w;
    w = {s, s, s} * 24'h01F3A5 ^ 24'hA5C31E;
    w[5:0] = 6'((int'(s) * 7 + 3) % 40);
    return w;
  endfunction

  function automatic bit pick(input logic [23:0] w, input logic [34:0] q, input bit t);
    int c;
    bit v;
    c = int'(w[5:0]);
    v = (c < 35) ? q[c] : (c == 35) ? t : 1'b0;
    return v ^ w[14];
  endfunction

  task automatic cyc(input bit r, input bit i, input bit s, input logic [34:0] q,
                     input logic [23:0] w, input string tag);
    @(negedge clk);
    rst_n = r; ifc = i; step = s; qual = q; ctrl = w;
    if (!r || i) begin
      m_state = '0; m_flags = '0; m_cnt = '0; m_tc = 0; m_q = 0;
    end else if (!s) begin
      m_q = pick(w, q, m_tc);
    end else begin
      m_state = m_q ? w[13:6] : m_state + 8'd1;
      if (int'(w[21:17]) < 17) begin
        if (w[23:22] == 2'b01) m_flags[w[21:17]] = 1'b1;
        else if (w[23:22] == 2'b10) m_flags[w[21:17]] = 1'b0;
      end
      if (w[15]) begin m_cnt = '0; m_tc = 0; end
      else if (w[16]) begin
        if (m_cnt == 4'hF) m_tc = 1;
        m_cnt = m_cnt + 4'd1;
      end
    end
    @(posedge clk); #1;
    checks++;
    if (state !== m_state || flags !== m_flags || cnt !== m_cnt || tc !== m_tc) begin
      errors++;
      $display("FAIL %s: state=%h flags=%h cnt=%h tc=%b expected state=%h flags=%h cnt=%h tc=%b",
               tag, state, flags, cnt, tc, m_state, m_flags, m_cnt, m_tc);
    end
  endtask

  task automatic pair(input logic [34:0] q, input logic [23:0] w, input string tag);
    cyc(1, 0, 0, q, w, tag);
    cyc(1, 0, 1, q, w, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    cyc(0, 0, 0, '0, '0, "R1 power-up");
    cyc(0, 0, 1, '1, mkw(0, 8'h33, 0, 0, 1, 3, 1), "R1 held");

    pair('0, mkw(40, 8'h77, 0, 0, 0, 0, 0), "R5 unused code reads 0 (R4 increment)");
    pair('0, mkw(40, 8'h77, 1, 0, 0, 0, 0), "R6 inverted unused code (R3 jump)");
    pair(35'h2_0000_0000, mkw(33, 8'h12, 0, 0, 0, 0, 0), "R5 code 33 high");
    pair(35'h4_0000_0000, mkw(33, 8'h99, 0, 0, 0, 0, 0), "R5 code 33 low");
    pair(35'h0_0000_0002, mkw(1, 8'h44, 1, 0, 0, 0, 0), "R6 inverted true");

    cyc(1, 0, 0, 35'h20, mkw(5, 8'hA0, 0, 0, 0, 0, 0), "R7 sample");
    cyc(1, 0, 0, 35'h20, mkw(5, 8'hA0, 0, 0, 0, 0, 0), "R2 no step");
    cyc(1, 0, 1, 35'h00, mkw(5, 8'hA0, 0, 0, 0, 0, 0), "R7 held qualifier");

    pair('0, mkw(40, 8'hFF, 1, 0, 0, 0, 0), "R3 jump to FF");
    pair('0, mkw(40, 8'h00, 0, 0, 0, 0, 0), "R4 wrap to 00");

    pair('0, mkw(40, 0, 0, 0, 0, 16, 1), "R8 set flag 16");
    pair('0, mkw(40, 0, 0, 0, 0, 2, 1), "R8 set flag 2");
    pair('0, mkw(40, 0, 0, 0, 0, 16, 2), "R8 clear flag 16");
    pair('0, mkw(40, 0, 0, 0, 0, 20, 1), "R8 index out of range");
    pair('0, mkw(40, 0, 0, 0, 0, 2, 3), "R8 op 11 ignored");

    pair('0, mkw(40, 0, 0, 1, 1, 0, 0), "R9 clear beats increment");
    for (int k = 0; k < 15; k++) pair('0, mkw(40, 0, 0, 0, 1, 0, 0), "R9 count");
    pair('0, mkw(35, 8'h5C, 0, 0, 1, 0, 0), "R9 wrap sets indication");
    pair('0, mkw(35, 8'h5C, 0, 0, 0, 0, 0), "R5 code 35 selects indication (R3)");
    pair('0, mkw(40, 0, 0, 0, 1, 0, 0), "R9 sticky after wrap");
    pair('0, mkw(35, 8'h6D, 0, 1, 0, 0, 0), "R9 clear drops indication");

    cyc(1, 1, 1, '1, mkw(40, 8'h11, 1, 0, 1, 1, 1), "R1 interface clear");

    for (int n = 0; n < 3000; n++) begin
      logic [34:0] q;
      bit s, i, r;
      q = {$urandom(), $urandom()};
      s = ($urandom() % 3) != 0;
      i = ($urandom() % 97) == 0;
      r = ($urandom() % 211) != 0;
      cyc(r, i, s, q, rom(m_state),
          (!r || i) ? "R1 random" : !s ? "R2 random" : m_q ? "R3 random" : "R4 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule